// File: doc/BRIEF.md
# Triggered Waveform Accumulator

This block sums repeated records of one sampled signal into on-chip memory, point by point. It waits to be armed. Each rising edge of the trigger input then starts one record. The record takes the next `cfg_len` valid samples, and the sample at position k of a record lands in sum word k. The first record after a reset or clear overwrites the words with the raw sample, so no separate zeroing pass over the memory is needed. Each later record adds its samples onto the words that are already there.

Each sum word is a 32-bit unsigned integer. It is wide enough for 2^18 records of 14-bit samples, and it is never divided. The host divides by `rec_count` to obtain an average. The engine rearms at the end of each record with no dead time, so a trigger one clock after the last sample of a record is taken. When the number of finished records equals `cfg_target`, the engine raises `done` and stops accumulating. A host can then read the words through a one-cycle read port. Pulsing `start` with a larger target resumes accumulation onto the existing sums.

The add path is a three-stage read-modify-write pipeline: read, add, write. It takes one sample per clock. A forwarding register covers a read that meets a write still in flight to the same word, which happens with one-sample records.

Top module: `wave_accum_top`

## Requirements
- R1: After `rst` or a one-cycle `clear` pulse, `done`, `overrun`, `busy` and `rd_valid` are 0 and `rec_count` is 0.
- R2: Once armed, a trigger rising edge (`trig` high in a cycle after a cycle with it low) starts a record. The next `cfg_len` cycles with `smp_valid` high supply the samples for indices 0 to `cfg_len`-1 in order. Cycles with `smp_valid` low do not advance the index.
- R3: In the first record after a reset or clear, each word is set to the unsigned sample, whatever the memory held before. In every later record, the unsigned sample is added to the 32-bit word.
- R4: `rec_count` rises by one per completed record. `done` goes high once `rec_count` equals `cfg_target`. While `done` is high, triggers and samples change neither the sums nor `busy`.
- R5: A trigger edge in the cycle right after the cycle that supplied a record's last sample starts the next record, with no sample lost.
- R6: A trigger edge while a record is being captured (`busy` high) is ignored, and the record continues. It sets `overrun`, which stays high until reset or clear.
- R7: With `done` high, `rd_en` high with `rd_addr` = k gives `rd_valid` = 1 and `rd_data` = sum word k after the next clock edge. With `done` low, `rd_valid` stays 0.
- R8: Records of length 1 fed back to back (trigger, sample, trigger, sample, …) accumulate correctly into word 0.
- R9: `start` with `rec_count` < `cfg_target` drops `done` and rearms, and the new records add onto the existing sums. `start` with `rec_count` ≥ `cfg_target` has no effect.
- R10: Trigger edges before the first `start` after a reset or clear are ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | One-cycle pulse: drop all progress, disarm, next record overwrites |
| start | input | 1 | One-cycle pulse: arm for records until the target is met |
| cfg_len | input | ADDR_W+1 | Samples per record (1 to 2^ADDR_W) |
| cfg_target | input | CNT_W | Number of records to accumulate |
| trig | input | 1 | Record trigger, rising edge active |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Unsigned sample |
| busy | output | 1 | A record is being captured |
| overrun | output | 1 | Sticky: a trigger arrived during capture |
| done | output | 1 | Target record count reached |
| rec_count | output | CNT_W | Completed records since clear |
| rd_en | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Host read index |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | SUM_W | Sum word read back |

## Verification
The bench builds the block with `ADDR_W` = 4, a 16-word memory, and keeps the 14-bit samples and 32-bit sums. With this depth a full-depth record takes only 16 samples, so records that use the whole memory, short records, one-sample records that exercise the forwarding path, and records with gaps in the strobe all run in a few hundred cycles each. Full-scale samples check the carry into the upper sum bits. Directed sequences then cover triggers before arming, triggers during capture, resuming with a raised target, and the frozen state after `done`.

// File: rtl/wacc_pkg.sv
package wacc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2
  } acq_state_e;
endpackage

// File: rtl/wacc_ctrl.sv
module wacc_ctrl
  import wacc_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 19
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                start,
  input  logic [ADDR_W:0]     cfg_len,
  input  logic [CNT_W-1:0]    cfg_target,
  input  logic                trig,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                fire,
  output logic [ADDR_W-1:0]   fire_idx,
  output logic [SAMPLE_W-1:0] fire_data,
  output logic                fire_first,
  output logic                fire_last,
  output logic                busy,
  output logic                overrun
);
  localparam logic [ADDR_W:0] LEN_ONE = 1;
  localparam logic [CNT_W:0]  CNT_ONE = 1;
  localparam logic [ADDR_W-1:0] IDX_MAX = '1;

  acq_state_e          state;
  logic                trig_q;
  logic                trig_edge;
  logic [ADDR_W-1:0]   idx;
  logic [CNT_W-1:0]    issued;
  logic                first_rec;

  assign trig_edge  = trig & ~trig_q;
  assign fire       = (state == ST_CAPT) && smp_valid;
  assign fire_idx   = idx;
  assign fire_data  = smp_data;
  assign fire_first = first_rec;
  assign fire_last  = (({1'b0, idx} + LEN_ONE) >= cfg_len) || (idx == IDX_MAX);
  assign busy       = (state == ST_CAPT);

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state     <= ST_IDLE;
      idx       <= '0;
      issued    <= '0;
      first_rec <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      if (start && state == ST_IDLE && issued < cfg_target)
        state <= ST_ARMED;
      if (trig_edge) begin
        if (state == ST_CAPT) begin
          overrun <= 1'b1;
        end else if (state == ST_ARMED) begin
          state <= ST_CAPT;
          idx   <= '0;
        end
      end
      if (fire) begin
        idx <= idx + 1'b1;
        if (fire_last) begin
          first_rec <= 1'b0;
          issued    <= issued + 1'b1;
          state     <= (({1'b0, issued} + CNT_ONE) >= {1'b0, cfg_target}) ? ST_IDLE : ST_ARMED;
        end
      end
    end
  end

  // R6: overrun only rises out of a capture, and holds until clear
  p_ovr_from_capture_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(state) == ST_CAPT);
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clear) |=> overrun);
  // R10: capture is only ever entered from the armed state
  p_capt_from_armed_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && $past(state) != ST_CAPT) |-> $past(state) == ST_ARMED);
endmodule

// File: rtl/wacc_rmw.sv
module wacc_rmw #(
  parameter int SAMPLE_W = 14,
  parameter int SUM_W    = 32,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [ADDR_W-1:0]   fire_idx,
  input  logic [SAMPLE_W-1:0] fire_data,
  input  logic                fire_first,
  input  logic                fire_last,
  input  logic                done,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_valid,
  output logic [SUM_W-1:0]    rd_data,
  output logic                wr_last
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = SUM_W - SAMPLE_W;

  typedef struct packed {
    logic                vld;
    logic                first;
    logic                last;
    logic [ADDR_W-1:0]   addr;
    logic [SAMPLE_W-1:0] data;
  } rd_stage_t;

  typedef struct packed {
    logic              vld;
    logic              last;
    logic [ADDR_W-1:0] addr;
    logic [SUM_W-1:0]  sum;
  } wr_stage_t;

  logic [SUM_W-1:0] mem [DEPTH];
  logic [SUM_W-1:0] mem_q;
  logic [ADDR_W-1:0] raddr;
  rd_stage_t        s1;
  wr_stage_t        s2;
  logic             fwd_hit;
  logic [SUM_W-1:0] fwd_val;
  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] new_sum;

  assign raddr = fire ? fire_idx : rd_addr;

  always_ff @(posedge clk) begin
    mem_q <= mem[raddr];
    if (s2.vld) mem[s2.addr] <= s2.sum;
  end

  always_comb begin
    base    = fwd_hit ? fwd_val : mem_q;
    new_sum = s1.first ? {{PAD_W{1'b0}}, s1.data}
                       : base + {{PAD_W{1'b0}}, s1.data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= '0;
      s2       <= '0;
      fwd_hit  <= 1'b0;
      fwd_val  <= '0;
      rd_valid <= 1'b0;
    end else begin
      s1.vld   <= fire;
      s1.first <= fire_first;
      s1.last  <= fire_last;
      s1.addr  <= fire_idx;
      s1.data  <= fire_data;
      s2.vld   <= s1.vld;
      s2.last  <= s1.last;
      s2.addr  <= s1.addr;
      s2.sum   <= new_sum;
      fwd_hit  <= fire && s2.vld && (s2.addr == fire_idx);
      fwd_val  <= s2.sum;
      rd_valid <= rd_en && done && !fire;
    end
  end

  assign rd_data = mem_q;
  assign wr_last = s2.vld && s2.last;

  // R4: no write reaches the memory while the sums are frozen
  p_frozen_when_done_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !s2.vld);
  // R7: host read never shares a cycle with an accumulation read
  p_host_read_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(fire));
endmodule

// File: rtl/wacc_tally.sv
module wacc_tally #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_target,
  input  logic             wr_last,
  output logic [CNT_W-1:0] rec_count,
  output logic             done
);
  localparam logic [CNT_W:0] CNT_ONE = 1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rec_count <= '0;
      done      <= 1'b0;
    end else begin
      if (start && rec_count < cfg_target)
        done <= 1'b0;
      if (wr_last) begin
        rec_count <= rec_count + 1'b1;
        if (({1'b0, rec_count} + CNT_ONE) >= {1'b0, cfg_target})
          done <= 1'b1;
      end
    end
  end

  // R4: the record count moves by at most one per clock
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (rec_count == $past(rec_count) || rec_count == $past(rec_count) + 1'b1));
endmodule

// File: rtl/wave_accum_top.sv
module wave_accum_top #(
  parameter int SAMPLE_W = 14,
  parameter int SUM_W    = 32,
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 19
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                start,
  input  logic [ADDR_W:0]     cfg_len,
  input  logic [CNT_W-1:0]    cfg_target,
  input  logic                trig,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                busy,
  output logic                overrun,
  output logic                done,
  output logic [CNT_W-1:0]    rec_count,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_valid,
  output logic [SUM_W-1:0]    rd_data
);
  logic                fire;
  logic [ADDR_W-1:0]   fire_idx;
  logic [SAMPLE_W-1:0] fire_data;
  logic                fire_first;
  logic                fire_last;
  logic                wr_last;

  wacc_ctrl #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .clear(clear), .start(start),
    .cfg_len(cfg_len), .cfg_target(cfg_target),
    .trig(trig), .smp_valid(smp_valid), .smp_data(smp_data),
    .fire(fire), .fire_idx(fire_idx), .fire_data(fire_data),
    .fire_first(fire_first), .fire_last(fire_last),
    .busy(busy), .overrun(overrun)
  );

  wacc_rmw #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .ADDR_W(ADDR_W)) rmw_i (
    .clk(clk), .rst(rst), .fire(fire), .fire_idx(fire_idx),
    .fire_data(fire_data), .fire_first(fire_first), .fire_last(fire_last),
    .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_last(wr_last)
  );

  wacc_tally #(.CNT_W(CNT_W)) tally_i (
    .clk(clk), .rst(rst), .clear(clear), .start(start),
    .cfg_target(cfg_target), .wr_last(wr_last),
    .rec_count(rec_count), .done(done)
  );

  // R4: capturing and the finished state never overlap
  p_busy_excl_done_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
endmodule

// File: tb/wave_accum_top_tb_top.sv
module wave_accum_top_tb_top;
  localparam int SW = 14;
  localparam int QW = 32;
  localparam int AW = 4;
  localparam int CW = 19;
  localparam int ROWS = 5;
  // len, target, seed (0 = full-scale samples), gap between samples
  localparam int VEC [ROWS][4] = '{
    '{16, 3, 5, 0}, '{5, 4, 7, 1}, '{1, 6, 3, 0}, '{16, 2, 0, 0}, '{7, 3, 11, 1}};

  logic clk = 1'b0;
  logic rst, clear, start, trig, smp_valid, rd_en;
  logic [AW:0] cfg_len;
  logic [CW-1:0] cfg_target;
  logic [SW-1:0] smp_data;
  logic [AW-1:0] rd_addr;
  logic busy, overrun, done, rd_valid;
  logic [CW-1:0] rec_count;
  logic [QW-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic [QW-1:0] exp_sum [16];

  always #10 clk = ~clk;

  wave_accum_top #(.SAMPLE_W(SW), .SUM_W(QW), .ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .clear(clear), .start(start), .cfg_len(cfg_len),
    .cfg_target(cfg_target), .trig(trig), .smp_valid(smp_valid), .smp_data(smp_data),
    .busy(busy), .overrun(overrun), .done(done), .rec_count(rec_count),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [SW-1:0] smp(int seed, int r, int i);
    if (seed == 0) return '1;
    return SW'((seed * 1237 + r * 977 + i * 61 + seed * r * i) % 16384);
  endfunction

  task automatic chk(string req, logic [QW-1:0] act, logic [QW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic pulse_clear();
    clear = 1'b1; @(negedge clk); clear = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic run_rec(int len, int seed, int r, bit gap, bit first);
    trig = 1'b1; smp_valid = 1'b0; @(negedge clk); trig = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (gap) begin smp_valid = 1'b0; @(negedge clk); end
      smp_valid = 1'b1;
      smp_data = smp(seed, r, i);
      exp_sum[i] = first ? QW'(smp_data) : exp_sum[i] + QW'(smp_data);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic read_all(int len, string req);
    for (int i = 0; i < len; i++) begin
      rd_en = 1'b1; rd_addr = AW'(i); @(negedge clk);
      chk(req, rd_valid ? rd_data : 32'hDEAD_BEEF, exp_sum[i]);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; clear = 1'b0; start = 1'b0; trig = 1'b0; smp_valid = 1'b0;
    smp_data = '0; rd_en = 1'b0; rd_addr = '0; cfg_len = 5'd4; cfg_target = 19'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 count", rec_count, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // Table walk: R2 R3 R4 R5 R8 R7
    for (int v = 0; v < ROWS; v++) begin
      pulse_clear();
      cfg_len = (AW + 1)'(VEC[v][0]);
      cfg_target = CW'(VEC[v][1]);
      pulse_start();
      for (int r = 0; r < VEC[v][1]; r++)
        run_rec(VEC[v][0], VEC[v][2], r, VEC[v][3] != 0, r == 0);
      repeat (4) @(negedge clk);
      chk("R4 done", done, 1);
      chk("R4 count", rec_count, QW'(VEC[v][1]));
      chk("R5 no overrun on back-to-back", overrun, 0);
      chk("R4 idle", busy, 0);
      read_all(VEC[v][0], (VEC[v][0] == 1) ? "R8 same-index sums" : "R3 sums");
    end

    // R10: trigger before start ignored
    pulse_clear();
    chk("R1 clear done", done, 0);
    chk("R1 clear count", rec_count, 0);
    cfg_len = 5'd4; cfg_target = 19'd2;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk("R10 busy", busy, 0);
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1; smp_data = 14'h1111; @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 count", rec_count, 0);
    pulse_start();
    run_rec(4, 21, 0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    rd_en = 1'b1; rd_addr = '0; @(negedge clk); rd_en = 1'b0;
    chk("R7 no read before done", rd_valid, 0);
    run_rec(4, 21, 1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    read_all(4, "R10 sums exclude unarmed samples");

    // R9: resume with raised target
    cfg_target = 19'd3;
    pulse_start();
    chk("R9 done drops", done, 0);
    run_rec(4, 21, 2, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9 done again", done, 1);
    chk("R9 count", rec_count, 3);
    read_all(4, "R9 resumed sums");
    // start with target already met: no effect, sums frozen
    pulse_start();
    chk("R9 start no effect", done, 1);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk("R4 busy while done", busy, 0);
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1; smp_data = 14'h2222; @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 count frozen", rec_count, 3);
    read_all(4, "R4 sums frozen");

    // R6: trigger during capture
    pulse_clear();
    cfg_len = 5'd4; cfg_target = 19'd1;
    pulse_start();
    trig = 1'b1; @(negedge clk);
    trig = 1'b0; smp_valid = 1'b1; smp_data = 14'd100; exp_sum[0] = 100; @(negedge clk);
    trig = 1'b1; smp_data = 14'd200; exp_sum[1] = 200; @(negedge clk);
    trig = 1'b0; smp_data = 14'd300; exp_sum[2] = 300; @(negedge clk);
    smp_data = 14'd400; exp_sum[3] = 400; @(negedge clk);
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 overrun set", overrun, 1);
    chk("R6 one record", rec_count, 1);
    read_all(4, "R6 record intact");
    chk("R6 overrun sticky", overrun, 1);
    pulse_clear();
    chk("R1 clear overrun", overrun, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule